// File: doc/BRIEF.md
# Prioritised Daisy-Chain Interrupt Requester

This block is the device-side half of a vectored interrupt scheme. The bus has four request levels and one acknowledge line that all levels share. The acknowledge is threaded through every device in a daisy chain: it enters each device on an input pin and leaves on an output pin. A device drives a request on one configured level. When an acknowledge reaches it, the device decides whether to keep the grant or hand it on down the chain.

The device keeps an acknowledge only when two things hold: it has a request outstanding, and none of the levels above its own is being requested elsewhere on the bus. When it keeps the grant, it answers the read strobe with a reply and places its vector on the low data lines. It also withdraws its request. When it does not keep the grant, it forwards the acknowledge unchanged. The decision is taken once, on the rising edge of the acknowledge, and is held until that acknowledge ends. A simpler single-level mode disables the watch on higher levels, so the device claims any acknowledge while a request is pending.

Top module: `irq_chain_requester`

## Requirements
- R1: After reset, `irq_out`, `ack_out`, `reply_out` and `data_out` are all zero, and no request is pending.
- R2: A one-cycle pulse on `req_set` makes `irq_out` equal to a one-hot value one clock later. The asserted bit has index `lvl_sel`, where code 3 is the highest priority and code 0 the lowest. The bit stays asserted until the request is claimed.
- R3: With no request pending, a rising `ack_in` is passed on: `ack_out` rises one clock after `ack_in` is first sampled high, and it falls one clock after `ack_in` is sampled low. `reply_out` stays low throughout.
- R4: With a request pending, `multi_en` = 1, and any bit of `irq_lines_in` above index `lvl_sel` asserted, an arriving acknowledge is forwarded, and the request stays asserted on `irq_out`.
- R5: With a request pending and no higher line blocking, an arriving acknowledge is claimed. One clock later `reply_out` = 1, `ack_out` stays 0, `data_out` carries `vec_cfg` in its low bits with zeros above, and `irq_out` returns to zero.
- R6: Request lines at or below the device's own level never block a claim. With `multi_en` = 0, no line blocks a claim.
- R7: Once taken, the claim-or-pass decision holds for the whole acknowledge. Changes on `irq_lines_in` or `req_set` during the acknowledge do not alter `ack_out` or `reply_out`.
- R8: A claimed grant is released only once `ack_in` and `din` are both low. `reply_out` and `data_out` return to zero one clock after that.
- R9: A request raised while an acknowledge is being forwarded through the device does not take that acknowledge. It waits and claims the next one.
- R10: A `req_set` pulse in the same cycle as a claim leaves a new request pending, so `irq_out` stays asserted after the claim.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| lvl_sel | input | LW (2) | Configured request level, 3 highest |
| multi_en | input | 1 | 1: watch higher levels; 0: single-level behaviour |
| vec_cfg | input | VW (8) | Vector supplied on a claim |
| req_set | input | 1 | Pulse to raise an interrupt request |
| irq_lines_in | input | NLEV (4) | Observed request lines of the bus |
| irq_out | output | NLEV (4) | This device's request drive, one-hot |
| ack_in | input | 1 | Acknowledge arriving from upstream |
| ack_out | output | 1 | Acknowledge forwarded downstream |
| din | input | 1 | Read strobe from the bus master |
| reply_out | output | 1 | Reply while the vector is on the data lines |
| data_out | output | DW (16) | Data lines, vector in the low VW bits |

## Verification
Two events can collide. A fresh request can arrive in the same clock edge as a claim, and a request can appear while the device is already forwarding an acknowledge. The first case is provoked by raising `req_set` in the cycle that `ack_in` first rises over an already pending request. It passes only if the reply appears and `irq_out` stays set. The second case pulses `req_set` mid-grant. It passes only if `ack_out` holds, no reply appears, and the following grant is claimed. Random rounds vary level, mode, bus lines and vector, and compare each outcome with a bench model of the priority rule.

// File: rtl/irq_chain_pkg.sv
package irq_chain_pkg;
  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_PASS  = 2'd1,
    ST_CLAIM = 2'd2
  } chain_st_e;
endpackage

// File: rtl/irq_prio_screen.sv
module irq_prio_screen #(
  parameter int NLEV = 4,
  localparam int LW = $clog2(NLEV)
) (
  input  logic [LW-1:0]   lvl_sel,
  input  logic            multi_en,
  input  logic [NLEV-1:0] irq_lines_in,
  output logic            block
);
  logic [NLEV-1:0] above;

  generate
    for (genvar i = 0; i < NLEV; i++) begin : g_above
      assign above[i] = irq_lines_in[i] && (LW'(i) > lvl_sel);
    end
  endgenerate

  assign block = multi_en && (|above);
endmodule

// File: rtl/irq_req_latch.sv
module irq_req_latch #(
  parameter int NLEV = 4,
  localparam int LW = $clog2(NLEV)
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            req_set,
  input  logic            claim_now,
  input  logic [LW-1:0]   lvl_sel,
  output logic            pending,
  output logic [NLEV-1:0] irq_out
);
  logic            pend_n;
  logic [NLEV-1:0] irq_n;

  assign pend_n = req_set || (pending && !claim_now);

  generate
    for (genvar i = 0; i < NLEV; i++) begin : g_drv
      assign irq_n[i] = pend_n && (lvl_sel == LW'(i));
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (rst) begin
      pending <= 1'b0;
      irq_out <= '0;
    end else begin
      pending <= pend_n;
      irq_out <= irq_n;
    end
  end

  AST_IRQ_ONEHOT: assert property (@(posedge clk) disable iff (rst)
    $onehot0(irq_out)); // R2
  AST_CLAIM_DROPS: assert property (@(posedge clk) disable iff (rst)
    (claim_now && !req_set) |=> (irq_out == '0)); // R5
  AST_RACE_KEEPS: assert property (@(posedge clk) disable iff (rst)
    (claim_now && req_set) |=> pending); // R10
endmodule

// File: rtl/irq_grant_fsm.sv
module irq_grant_fsm
  import irq_chain_pkg::*;
(
  input  logic clk,
  input  logic rst,
  input  logic ack_in,
  input  logic din,
  input  logic pending,
  input  logic block,
  output logic claim_now,
  output logic rel_now,
  output logic ack_out,
  output logic reply_out
);
  chain_st_e st, st_n;
  logic      ack_q;
  logic      ack_rise;

  assign ack_rise  = ack_in && !ack_q;
  assign claim_now = (st == ST_IDLE) && ack_rise && pending && !block;
  assign rel_now   = (st == ST_CLAIM) && !ack_in && !din;

  always_comb begin
    st_n = st;
    unique case (st)
      ST_IDLE:  if (ack_rise) st_n = claim_now ? ST_CLAIM : ST_PASS;
      ST_PASS:  if (!ack_in) st_n = ST_IDLE;
      ST_CLAIM: if (rel_now) st_n = ST_IDLE;
      default:  st_n = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st        <= ST_IDLE;
      ack_q     <= 1'b0;
      ack_out   <= 1'b0;
      reply_out <= 1'b0;
    end else begin
      st        <= st_n;
      ack_q     <= ack_in;
      ack_out   <= (st_n == ST_PASS);
      reply_out <= (st_n == ST_CLAIM);
    end
  end

  AST_FREE_PASS: assert property (@(posedge clk) disable iff (rst)
    (st == ST_IDLE && ack_rise && !pending) |=> (ack_out && !reply_out)); // R3
  AST_BLOCKED_PASS: assert property (@(posedge clk) disable iff (rst)
    (st == ST_IDLE && ack_rise && pending && block) |=> (ack_out && !reply_out)); // R4
  AST_CLAIM_REPLY: assert property (@(posedge clk) disable iff (rst)
    (st == ST_IDLE && ack_rise && pending && !block) |=> (reply_out && !ack_out)); // R5
  AST_HOLD_PASS: assert property (@(posedge clk) disable iff (rst)
    (ack_out && ack_in) |=> ack_out); // R7
  AST_HOLD_REPLY: assert property (@(posedge clk) disable iff (rst)
    (reply_out && (ack_in || din)) |=> reply_out); // R8
  AST_RELEASE: assert property (@(posedge clk) disable iff (rst)
    (reply_out && !ack_in && !din) |=> !reply_out); // R8
endmodule

// File: rtl/irq_vec_drive.sv
module irq_vec_drive #(
  parameter int DW = 16,
  parameter int VW = 8
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          claim_now,
  input  logic          rel_now,
  input  logic [VW-1:0] vec_cfg,
  output logic [DW-1:0] data_out
);
  always_ff @(posedge clk) begin
    if (rst || rel_now) data_out <= '0;
    else if (claim_now) data_out <= DW'(vec_cfg);
  end
endmodule

// File: rtl/irq_chain_requester.sv
module irq_chain_requester #(
  parameter int NLEV = 4,
  parameter int DW   = 16,
  parameter int VW   = 8,
  localparam int LW  = $clog2(NLEV)
) (
  input  logic            clk,
  input  logic            rst,
  input  logic [LW-1:0]   lvl_sel,
  input  logic            multi_en,
  input  logic [VW-1:0]   vec_cfg,
  input  logic            req_set,
  input  logic [NLEV-1:0] irq_lines_in,
  output logic [NLEV-1:0] irq_out,
  input  logic            ack_in,
  output logic            ack_out,
  input  logic            din,
  output logic            reply_out,
  output logic [DW-1:0]   data_out
);
  logic pending, block, claim_now, rel_now;

  irq_prio_screen #(.NLEV(NLEV)) u_screen (
    .lvl_sel(lvl_sel), .multi_en(multi_en),
    .irq_lines_in(irq_lines_in), .block(block)
  );

  irq_req_latch #(.NLEV(NLEV)) u_req (
    .clk(clk), .rst(rst), .req_set(req_set), .claim_now(claim_now),
    .lvl_sel(lvl_sel), .pending(pending), .irq_out(irq_out)
  );

  irq_grant_fsm u_fsm (
    .clk(clk), .rst(rst), .ack_in(ack_in), .din(din),
    .pending(pending), .block(block), .claim_now(claim_now),
    .rel_now(rel_now), .ack_out(ack_out), .reply_out(reply_out)
  );

  irq_vec_drive #(.DW(DW), .VW(VW)) u_vec (
    .clk(clk), .rst(rst), .claim_now(claim_now), .rel_now(rel_now),
    .vec_cfg(vec_cfg), .data_out(data_out)
  );

  AST_VEC_LOAD: assert property (@(posedge clk) disable iff (rst)
    $rose(reply_out) |-> (data_out == DW'($past(vec_cfg)))); // R5
  AST_ONE_WAY: assert property (@(posedge clk) disable iff (rst)
    !(ack_out && reply_out)); // R5
  AST_IDLE_DATA: assert property (@(posedge clk) disable iff (rst)
    !reply_out |-> (data_out == '0)); // R8
endmodule

// File: tb/tb_irq_chain_requester.sv
module tb_irq_chain_requester;
  localparam int NLEV = 4;
  localparam int DW = 16;
  localparam int VW = 8;
  localparam int LW = 2;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic [LW-1:0] lvl_sel = '0;
  logic multi_en = 1'b1;
  logic [VW-1:0] vec_cfg = '0;
  logic req_set = 1'b0;
  logic [NLEV-1:0] irq_lines_in = '0;
  logic [NLEV-1:0] irq_out;
  logic ack_in = 1'b0, din = 1'b0;
  logic ack_out, reply_out;
  logic [DW-1:0] data_out;

  int vectors = 0;
  int miscompares = 0;
  int cyc = 0;
  bit pend_m = 1'b0;

  always #2.5 clk = ~clk;

  irq_chain_requester #(.NLEV(NLEV), .DW(DW), .VW(VW)) dut (
    .clk(clk), .rst(rst), .lvl_sel(lvl_sel), .multi_en(multi_en),
    .vec_cfg(vec_cfg), .req_set(req_set), .irq_lines_in(irq_lines_in),
    .irq_out(irq_out), .ack_in(ack_in), .ack_out(ack_out), .din(din),
    .reply_out(reply_out), .data_out(data_out)
  );

  task automatic chk(input string rq, input logic [31:0] act, input logic [31:0] exp);
    vectors++;
    if (act !== exp) begin
      miscompares++;
      $display("FAIL %s actual=%0h expected=%0h", rq, act, exp);
    end
  endtask

  function automatic bit exp_claim(bit pend, bit multi, logic [LW-1:0] lvl,
                                   logic [NLEV-1:0] lines);
    bit blk = 1'b0;
    for (int i = 0; i < NLEV; i++)
      if (i > int'(lvl) && lines[i]) blk = 1'b1;
    return pend && !(multi && blk);
  endfunction

  function automatic logic [NLEV-1:0] onehot(logic [LW-1:0] lvl);
    return NLEV'(1) << lvl;
  endfunction

  task automatic pulse_req();
    @(negedge clk) req_set = 1'b1;
    @(negedge clk) req_set = 1'b0;
    pend_m = 1'b1;
  endtask

  task automatic raise_ack();
    @(negedge clk) begin ack_in = 1'b1; din = 1'b1; end
    @(negedge clk);
  endtask

  task automatic drop_ack();
    @(negedge clk) begin ack_in = 1'b0; din = 1'b0; end
    @(negedge clk);
  endtask

  task automatic check_grant(input string rq, input bit claim);
    chk({rq, " ack_out"}, 32'(ack_out), 32'(!claim));
    chk({rq, " reply_out"}, 32'(reply_out), 32'(claim));
    chk({rq, " data_out"}, 32'(data_out), claim ? 32'(vec_cfg) : 32'd0);
  endtask

  task automatic full_grant(input string rq);
    bit c;
    c = exp_claim(pend_m, multi_en, lvl_sel, irq_lines_in);
    raise_ack();
    check_grant(rq, c);
    if (c) pend_m = 1'b0;
    drop_ack();
    chk({rq, " released ack"}, 32'(ack_out), 0);
    chk({rq, " released reply"}, 32'(reply_out), 0);
    chk({rq, " released data"}, 32'(data_out), 0);
    chk({rq, " irq after"}, 32'(irq_out), pend_m ? 32'(onehot(lvl_sel)) : 32'd0);
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000) begin
      miscompares++;
      $display("FAIL watchdog actual=%0d expected=<150000", cyc);
      $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd4242));
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R1 reset state
    chk("R1 irq_out", 32'(irq_out), 0);
    chk("R1 ack_out", 32'(ack_out), 0);
    chk("R1 reply_out", 32'(reply_out), 0);
    chk("R1 data_out", 32'(data_out), 0);

    // R3 free pass with nothing pending
    lvl_sel = 2'd1; vec_cfg = 8'h5A; multi_en = 1'b1;
    full_grant("R3 free pass");

    // R2 request raises one-hot on configured level
    pulse_req();
    chk("R2 irq one-hot", 32'(irq_out), 32'(4'b0010));

    // R4 higher level blocks in multi-level mode
    irq_lines_in = 4'b1000;
    full_grant("R4 blocked pass");

    // R6 lower and equal levels do not block; R5 claim with vector
    irq_lines_in = 4'b0011;
    full_grant("R5 R6 claim lower lines");
    chk("R5 irq cleared", 32'(irq_out), 0);

    // R6 single-level mode ignores higher lines
    multi_en = 1'b0; irq_lines_in = 4'b1100; vec_cfg = 8'hC3;
    pulse_req();
    full_grant("R6 single-level claim");
    multi_en = 1'b1;

    // R7 decision held while higher line drops mid-grant
    pulse_req();
    irq_lines_in = 4'b0100;
    raise_ack();
    check_grant("R7 pass taken", 1'b0);
    @(negedge clk) irq_lines_in = 4'b0000;
    @(negedge clk);
    check_grant("R7 pass held", 1'b0);
    drop_ack();
    full_grant("R7 later claim");

    // R9 request raised during a forwarded grant waits
    lvl_sel = 2'd2; vec_cfg = 8'h77;
    raise_ack();
    check_grant("R9 pass", 1'b0);
    pulse_req();
    check_grant("R9 still passing", 1'b0);
    chk("R9 irq pending", 32'(irq_out), 32'(4'b0100));
    drop_ack();
    full_grant("R9 next grant claims");

    // R10 new request in the same cycle as a claim
    pulse_req();
    @(negedge clk) begin req_set = 1'b1; ack_in = 1'b1; din = 1'b1; end
    @(negedge clk) req_set = 1'b0;
    check_grant("R10 claim", 1'b1);
    chk("R10 irq kept", 32'(irq_out), 32'(4'b0100));
    pend_m = 1'b1;

    // R8 reply held while din remains high
    @(negedge clk) ack_in = 1'b0;
    @(negedge clk);
    chk("R8 reply held", 32'(reply_out), 1);
    chk("R8 data held", 32'(data_out), 32'(vec_cfg));
    @(negedge clk) din = 1'b0;
    @(negedge clk);
    chk("R8 reply released", 32'(reply_out), 0);
    chk("R8 data released", 32'(data_out), 0);

    // random rounds (R4 R5 R6)
    for (int n = 0; n < 300; n++) begin
      @(negedge clk) begin
        lvl_sel = LW'($urandom_range(0, NLEV - 1));
        multi_en = 1'($urandom_range(0, 1));
        irq_lines_in = NLEV'($urandom);
        vec_cfg = VW'($urandom);
      end
      if ($urandom_range(0, 1) == 1) pulse_req();
      else @(negedge clk);
      chk("R2 random irq", 32'(irq_out), pend_m ? 32'(onehot(lvl_sel)) : 32'd0);
      full_grant("R4 R5 R6 random");
    end

    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end
endmodule